// File: doc/BRIEF.md
# LED Flash and Pin-Mux Controller

This block turns two mode-control bytes into the drive levels of two indicator LEDs and of one shared output pin. The first LED and the second LED each take an enable source: section activity from the playback engine, a fixed "on", or the stop-C bit. When flashing is selected, each LED is also gated by a flash phase. A slow tick toggles that phase. The second LED may run in phase with the first or in the opposite phase.

The shared pin serves one of two roles. It carries the second LED signal, or it acts as a plain stop output that shows the stop-C register bit through an inverting stage.

The flash phase is a two-state machine. PH_DARK is the reset state. The transition `tick_dark_to_lit` moves PH_DARK to PH_LIT on a flash tick, and `tick_lit_to_dark` moves PH_LIT back to PH_DARK on a flash tick. With no tick, each state holds. The LED gates and the pin mux are combinational from that state and the inputs, so the outputs change in the same cycle as the phase register or the inputs.

Top module: `led_mux_ctrl`

## Requirements
- R1: After reset the flash phase is PH_DARK, so with flashing selected `led1_o` is 0 even when its enable source is active.
- R2: The phase changes state at every rising clock edge on which `flash_tick` is 1, and holds at every edge on which it is 0.
- R3: With `mode_a[7]` = 0 (steady mode), each LED output equals its enable source.
- R4: With `mode_a[7]` = 1 (flash mode), `led1_o` is its enable source ANDed with the phase (PH_LIT = 1).
- R5: In flash mode with `mode_b[5]` = 0 (synchronous), `led2_o` is its enable source ANDed with the same phase as LED1.
- R6: In flash mode with `mode_b[5]` = 1 (alternating), `led2_o` is its enable source ANDed with the inverted phase.
- R7: The LED1 enable source is `section_active` when `mode_b[4]` = 1, and constant 1 when `mode_b[4]` = 0.
- R8: The LED2 enable source is `section_active` when `mode_b[3]` = 1, and `stop_c_bit` when `mode_b[3]` = 0.
- R9: `shared_o` equals `led2_o` when `mode_a[6]` = 1, and equals the inverse of `stop_c_bit` when `mode_a[6]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_a | input | MODE_W | First mode byte: bit 7 selects flash, bit 6 selects the shared-pin role |
| mode_b | input | MODE_W | Second mode byte: bit 5 selects alternating flash, bit 4 enables LED1 section control, bit 3 selects the LED2 source |
| section_active | input | 1 | Playback section in progress |
| stop_c_bit | input | 1 | Stop-C register bit |
| flash_tick | input | 1 | One-cycle pulse that advances the flash phase |
| led1_o | output | 1 | First LED drive |
| led2_o | output | 1 | Second LED drive |
| shared_o | output | 1 | Shared pin: second LED or inverted stop-C |

## Verification
The hardest case to reach from the ports is knowing the flash phase, because no port shows it directly. The phase only becomes visible through an LED that is in flash mode and has an active source. The stimulus first sets flash mode with LED1 on a constant source. It then sends single tick pulses and holds idle stretches between them, which makes `led1_o` trace the phase edge by edge. Only after that does it switch the sync, alternate and shared-pin selections, while the phase is in a known state.

// File: rtl/led_mux_pkg.sv
package led_mux_pkg;
    // Bit positions that the mode decoding depends on
    localparam int A_FLASH_BIT   = 7;
    localparam int A_PINLED_BIT  = 6;
    localparam int B_ALT_BIT     = 5;
    localparam int B_SEC1_BIT    = 4;
    localparam int B_SEC2_BIT    = 3;
    localparam int NUM_LEDS      = 2;

    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } phase_e;
endpackage

// File: rtl/led_flash_fsm.sv
module led_flash_fsm
    import led_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic phase_o
);
    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_DARK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_DARK: if (tick_i) state_d = PH_LIT;   // tick_dark_to_lit
            PH_LIT:  if (tick_i) state_d = PH_DARK;  // tick_lit_to_dark
            default: state_d = PH_DARK;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_LIT:  phase_o = 1'b1;
            default: phase_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_gate.sv
module led_gate (
    input  logic src_i,
    input  logic flash_en_i,
    input  logic phase_i,
    input  logic invert_i,
    output logic led_o
);
    logic eff_phase;

    always_comb begin
        eff_phase = invert_i ? ~phase_i : phase_i;
        led_o     = flash_en_i ? (src_i & eff_phase) : src_i;
    end
endmodule

// File: rtl/led_pin_mux.sv
module led_pin_mux (
    input  logic sel_led_i,
    input  logic led2_i,
    input  logic stop_c_i,
    output logic pin_o
);
    // The stop role drives the pin through an inverting stage
    always_comb begin
        pin_o = sel_led_i ? led2_i : ~stop_c_i;
    end
endmodule

// File: rtl/led_mux_ctrl.sv
module led_mux_ctrl
    import led_mux_pkg::*;
#(
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_a,
    input  logic [MODE_W-1:0] mode_b,
    input  logic              section_active,
    input  logic              stop_c_bit,
    input  logic              flash_tick,
    output logic              led1_o,
    output logic              led2_o,
    output logic              shared_o
);
    localparam int TOP_BIT = A_FLASH_BIT;

    logic                phase_q;
    logic [NUM_LEDS-1:0] src;
    logic [NUM_LEDS-1:0] inv;
    logic [NUM_LEDS-1:0] led;

    led_flash_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (flash_tick),
        .phase_o (phase_q)
    );

    always_comb begin
        src[0] = mode_b[B_SEC1_BIT] ? section_active : 1'b1;
        src[1] = mode_b[B_SEC2_BIT] ? section_active : stop_c_bit;
        inv[0] = 1'b0;
        inv[1] = mode_b[B_ALT_BIT];
    end

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        led_gate u_gate (
            .src_i      (src[g]),
            .flash_en_i (mode_a[TOP_BIT]),
            .phase_i    (phase_q),
            .invert_i   (inv[g]),
            .led_o      (led[g])
        );
    end

    led_pin_mux u_pin (
        .sel_led_i (mode_a[A_PINLED_BIT]),
        .led2_i    (led[1]),
        .stop_c_i  (stop_c_bit),
        .pin_o     (shared_o)
    );

    assign led1_o = led[0];
    assign led2_o = led[1];
endmodule

// File: rtl/led_mux_ctrl_chk.sv
module led_mux_ctrl_chk #(
    parameter int MODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_a,
    input logic [MODE_W-1:0] mode_b,
    input logic              section_active,
    input logic              stop_c_bit,
    input logic              flash_tick,
    input logic              phase_q,
    input logic              led1_o,
    input logic              led2_o,
    input logic              shared_o
);
    assert_tick_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flash_tick |=> phase_q != $past(phase_q));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_tick |=> $stable(phase_q));

    assert_steady_free_led1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_a[7] && !mode_b[4]) |-> led1_o);

    assert_sync_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a[7] && !mode_b[5] && mode_b[4] && mode_b[3]) |-> (led1_o == led2_o));

    assert_alt_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a[7] && mode_b[5]) |-> !(led1_o && led2_o));

    assert_stop_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_a[6] |-> (shared_o == !stop_c_bit));
endmodule

bind led_mux_ctrl led_mux_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_a         (mode_a),
    .mode_b         (mode_b),
    .section_active (section_active),
    .stop_c_bit     (stop_c_bit),
    .flash_tick     (flash_tick),
    .phase_q        (phase_q),
    .led1_o         (led1_o),
    .led2_o         (led2_o),
    .shared_o       (shared_o)
);

// File: tb/led_mux_ctrl_bench.sv
`timescale 1ns/1ps
module led_mux_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_a = 8'h00;
    logic [7:0] mode_b = 8'h00;
    logic       section_active = 1'b0;
    logic       stop_c_bit = 1'b0;
    logic       flash_tick = 1'b0;
    logic       led1_o, led2_o, shared_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic exp_phase = 1'b0;

    always #4 clk = ~clk;

    led_mux_ctrl u_led_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .section_active(section_active), .stop_c_bit(stop_c_bit),
        .flash_tick(flash_tick), .led1_o(led1_o), .led2_o(led2_o),
        .shared_o(shared_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one tick pulse; sampling resumes on the following falling edge
    task automatic pulse_tick();
        flash_tick = 1'b1;
        @(negedge clk);
        flash_tick = 1'b0;
        exp_phase = ~exp_phase;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        mode_a = 8'h80; mode_b = 8'h00;  // flash, LED1 on constant source
        idle(1);
        check("R1", "led1 after reset", led1_o, 1'b0);
        pulse_tick();
        check("R2", "led1 after first tick", led1_o, 1'b1);
        idle(3);
        check("R2", "led1 holds without tick", led1_o, 1'b1);
        pulse_tick();
        check("R4", "led1 dark phase", led1_o, 1'b0);
    endtask

    task automatic t_steady();
        mode_a = 8'h40; mode_b = 8'h18; section_active = 1'b0;
        idle(1);
        check("R3", "led1 steady section off", led1_o, 1'b0);
        check("R8", "led2 steady section off", led2_o, 1'b0);
        section_active = 1'b1;
        idle(1);
        check("R3", "led1 steady section on", led1_o, 1'b1);
        check("R9", "shared as led2", shared_o, 1'b1);
        pulse_tick();
        check("R3", "led1 ignores phase in steady", led1_o, 1'b1);
    endtask

    task automatic t_sources();
        mode_a = 8'h00; mode_b = 8'h00; section_active = 1'b0; stop_c_bit = 1'b1;
        idle(1);
        check("R7", "led1 constant source", led1_o, 1'b1);
        check("R8", "led2 follows stop-C 1", led2_o, 1'b1);
        stop_c_bit = 1'b0;
        idle(1);
        check("R8", "led2 follows stop-C 0", led2_o, 1'b0);
        mode_b = 8'h10;
        idle(1);
        check("R7", "led1 section source off", led1_o, 1'b0);
    endtask

    task automatic t_flash_sync();
        mode_a = 8'hC0; mode_b = 8'h18; section_active = 1'b1;
        for (int k = 0; k < 4; k++) begin
            pulse_tick();
            check("R4", "led1 flash", led1_o, exp_phase);
            check("R5", "led2 sync", led2_o, exp_phase);
        end
        section_active = 1'b0;
        idle(1);
        check("R4", "led1 source off in flash", led1_o, 1'b0);
    endtask

    task automatic t_flash_alt();
        mode_a = 8'hC0; mode_b = 8'h38; section_active = 1'b1;
        for (int k = 0; k < 3; k++) begin
            pulse_tick();
            check("R6", "led1 alt", led1_o, exp_phase);
            check("R6", "led2 alt inverted", led2_o, ~exp_phase);
            check("R9", "shared tracks led2", shared_o, ~exp_phase);
        end
    endtask

    task automatic t_stop_pin();
        mode_a = 8'h00; mode_b = 8'h18; section_active = 1'b1; stop_c_bit = 1'b0;
        idle(1);
        check("R9", "shared stop-C 0", shared_o, 1'b1);
        stop_c_bit = 1'b1;
        idle(1);
        check("R9", "shared stop-C 1", shared_o, 1'b0);
        check("R8", "led2 still on section", led2_o, 1'b1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_steady();
        t_sources();
        t_flash_sync();
        t_flash_alt();
        t_stop_pin();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule